// File: doc/BRIEF.md
# DSP Host Command Port

This block is the byte-wide host side of a sound processor. A host bus writes command bytes and parameter bytes through a small register window and reads reply bytes back. The block decodes each command and works out how many parameter bytes follow it. It gathers those bytes and, when the last one arrives, updates a set of decoded values for downstream playback logic. These values are a sample-rate time constant, an output rate, a block length, a transfer descriptor and a test register.

Replies are kept on a last-in-first-out stack. A soft reset is guarded by an arming handshake on a separate offset, so a single stray write cannot reset the port. After a soft reset the stack holds one acknowledge byte, 0xAA, which the host reads to confirm that the port is alive. All register reads are combinational. A read of the reply offset pops the stack on the clock edge that ends the read cycle.

Top module: `dsp_host_port`

## Requirements
- R1: A write of 0x01 or 0x03 to offset 0x6 arms the soft reset. A following write of 0x00 to offset 0x6 performs the reset and disarms it. Any other value written to offset 0x6 (0xC6 included) disarms without resetting, and a 0x00 written while unarmed does nothing.
- R2: A soft reset drops any pending command and empties both the parameter buffer and the reply stack. It then leaves 0xAA as the only reply byte. The decoded outputs (time_const, rate, block_len, test_reg, xfer_*) keep their values.
- R3: A byte written at offset 0xC is taken as a new command when no parameter bytes are outstanding, and as a parameter byte otherwise. The command completes in the cycle its final parameter byte is written. cmd_pending is high while parameter bytes are outstanding.
- R4: Commands 0xB0 through 0xCF take three parameter bytes: a mode byte, then the count low byte, then the count high byte. On completion xfer_cmd, xfer_mode and xfer_count are loaded, and xfer_start is high for exactly one cycle.
- R5: Command 0x40 takes one byte, which goes to time_const. Commands 0x41 and 0x42 take two bytes, high byte first, which go to rate. Command 0x48 takes two bytes, low byte first, and block_len (17 bits) becomes that 16-bit value plus one.
- R6: Command 0xE4 takes one byte and stores it in test_reg. Command 0xE8 takes no bytes and pushes test_reg as a reply.
- R7: Command 0xE0 takes one byte. It discards every pending reply and pushes the bitwise inverse of that byte.
- R8: Command 0xE1 pushes the 16-bit VERSION parameter (default 0x0405) so that the major (high) byte is read first.
- R9: Any command code not named in R4 to R8 takes no parameter bytes and pushes no reply. The next byte at offset 0xC is therefore decoded as a command.
- R10: A read at offset 0xA returns the top reply byte and pops it, in last-in-first-out order. A read with the stack empty returns the byte most recently read from offset 0xA, which is 0x00 after a hardware reset.
- R11: A read of offset 0xE returns 0x80 while a reply is pending and 0x00 otherwise. A read of offset 0xC returns 0x00, meaning never busy. A read of any other offset returns 0xFF.
- R12: The reply stack holds REPLY_DEPTH (default 50) bytes, and a push that finds it full is dropped. The parameter buffer holds PBUF_DEPTH (default 10) bytes.
- R13: After the hardware reset input, the reply stack is empty, no command is pending, the port is unarmed, and all decoded outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| reply_pending | output | 1 | Reply stack not empty |
| cmd_pending | output | 1 | Parameter bytes outstanding |
| time_const | output | 8 | Sample-rate time constant |
| rate | output | 16 | Output rate |
| block_len | output | 17 | Block length (value plus one) |
| xfer_cmd | output | 8 | Last transfer command code |
| xfer_mode | output | 8 | Transfer mode byte |
| xfer_count | output | 16 | Transfer count field |
| xfer_start | output | 1 | One-cycle pulse when a transfer command completes |
| test_reg | output | 8 | Test register |

## Verification
The assertions assume that the host never asserts the read and write strobes in the same cycle. They also assume that bus_addr and bus_wdata are steady while a strobe is high. This rules out a pop and a push colliding on the reply stack. Every bench transaction raises one strobe for one cycle and then lowers it, and reads and writes never overlap, so the stimulus stays within these assumptions. The corner cases it exercises are a stack filled to its depth with further pushes dropped, a two-byte push that finds the stack full, and a soft reset that arrives while a command is still waiting for parameters.

// File: rtl/dsp_port_pkg.sv
package dsp_port_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFF_RESET  = 4'h6;
    localparam logic [ADDR_W-1:0] OFF_RDATA  = 4'hA;
    localparam logic [ADDR_W-1:0] OFF_CMD    = 4'hC;
    localparam logic [ADDR_W-1:0] OFF_STATUS = 4'hE;

    localparam logic [7:0] ACK_BYTE     = 8'hAA;
    localparam logic [7:0] CMD_TCONST   = 8'h40;
    localparam logic [7:0] CMD_RATE_A   = 8'h41;
    localparam logic [7:0] CMD_RATE_B   = 8'h42;
    localparam logic [7:0] CMD_BLKLEN   = 8'h48;
    localparam logic [7:0] CMD_INVERT   = 8'hE0;
    localparam logic [7:0] CMD_VERSION  = 8'hE1;
    localparam logic [7:0] CMD_TEST_WR  = 8'hE4;
    localparam logic [7:0] CMD_TEST_RD  = 8'hE8;
    localparam logic [7:0] XFER_LO      = 8'hB0;
    localparam logic [7:0] XFER_HI      = 8'hCF;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_SET  = 1'b1
    } arm_state_t;

    // request to the reply stack for one cycle
    typedef struct packed {
        logic       clear;
        logic [1:0] n;
        logic [7:0] b0;
        logic [7:0] b1;
    } push_req_t;

    function automatic logic is_xfer(input logic [7:0] c);
        return (c >= XFER_LO) && (c <= XFER_HI);
    endfunction

    function automatic logic [1:0] params_needed(input logic [7:0] c);
        logic [1:0] r;
        if (is_xfer(c)) begin
            r = 2'd3;
        end else begin
            case (c)
                CMD_TCONST, CMD_INVERT, CMD_TEST_WR: r = 2'd1;
                CMD_RATE_A, CMD_RATE_B, CMD_BLKLEN:  r = 2'd2;
                default:                             r = 2'd0;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dsp_rst_arm.sv
module dsp_rst_arm
    import dsp_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic       soft_rst
);
    arm_state_t st_q;

    assign soft_rst = wr_en && (wdata == 8'h00) && (st_q == ARM_SET);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ARM_IDLE;
        end else if (wr_en) begin
            if (wdata == 8'h01 || wdata == 8'h03) st_q <= ARM_SET;
            else                                  st_q <= ARM_IDLE;
        end
    end

    // R1
    rst_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (st_q == ARM_IDLE));

endmodule

// File: rtl/dsp_reply_lifo.sv
module dsp_reply_lifo
    import dsp_port_pkg::*;
#(
    parameter int DEPTH = 50
) (
    input  logic       clk,
    input  logic       rst,
    input  push_req_t  req,
    input  logic       pop,
    output logic [7:0] rd_byte,
    output logic       pending
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW:0] DEPTH_W = (CW+1)'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [CW-1:0] cnt_q;
    logic [7:0]    last_q;
    logic [CW:0]   base, base1, sum;
    logic [CW-1:0] cnt_nxt, top_idx;
    logic [7:0]    top_byte;

    assign top_idx  = cnt_q - 1'b1;
    assign top_byte = mem[top_idx];
    assign pending  = (cnt_q != '0);
    assign rd_byte  = pending ? top_byte : last_q;

    always_comb begin
        base = {1'b0, cnt_q};
        if (req.clear) base = '0;
        if (pop && base != '0) base = base - 1'b1;
        base1 = base + 1'b1;
        sum   = base + {{(CW-1){1'b0}}, req.n};
        cnt_nxt = (sum > DEPTH_W) ? DEPTH_W[CW-1:0] : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            last_q <= 8'h00;
        end else begin
            cnt_q <= cnt_nxt;
            if (pop && pending) last_q <= top_byte;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (req.n != 2'd0 && base == (CW+1)'(i))
                mem[i] <= req.b0;
            else if (req.n == 2'd2 && base1 == (CW+1)'(i))
                mem[i] <= req.b1;
        end
    end

    // R10
    pop_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && pending && !req.clear && req.n == 2'd0) |=> (cnt_q + 1'b1 == $past(cnt_q)));

    // R10
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !pending && req.n == 2'd0) |=> $stable(last_q));

    // R12
    depth_chk: assert property (@(posedge clk) disable iff (rst)
        {1'b0, cnt_q} <= DEPTH_W);

endmodule

// File: rtl/dsp_cmd_seq.sv
module dsp_cmd_seq
    import dsp_port_pkg::*;
#(
    parameter int          PBUF_DEPTH = 10,
    parameter logic [15:0] VERSION    = 16'h0405
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        soft_rst,
    input  logic        wr_en,
    input  logic [7:0]  wdata,
    output push_req_t   req,
    output logic        cmd_pending,
    output logic [7:0]  time_const,
    output logic [15:0] rate,
    output logic [16:0] block_len,
    output logic [7:0]  xfer_cmd,
    output logic [7:0]  xfer_mode,
    output logic [15:0] xfer_count,
    output logic        xfer_start,
    output logic [7:0]  test_reg
);
    localparam int PIW    = $clog2(PBUF_DEPTH + 1);
    localparam int NPARAM = 3;

    logic [1:0]     need_q;
    logic [7:0]     cmd_q;
    logic [PIW-1:0] pcnt_q;
    logic [7:0]     pbuf [PBUF_DEPTH];
    logic [7:0]     pv [NPARAM];
    logic           is_cmd, is_par, room, done;

    assign cmd_pending = (need_q != 2'd0);
    assign is_cmd = wr_en && !cmd_pending;
    assign is_par = wr_en && cmd_pending;
    assign room   = (pcnt_q < PIW'(PBUF_DEPTH));
    assign done   = is_par && room && ((pcnt_q + 1'b1) == PIW'(need_q));

    // parameter view with the byte arriving this cycle folded in
    for (genvar g = 0; g < NPARAM; g++) begin : g_pv
        assign pv[g] = (pcnt_q == PIW'(g)) ? wdata : pbuf[g];
    end

    always_comb begin
        req = '0;
        if (is_cmd) begin
            case (wdata)
                CMD_VERSION: begin
                    req.n  = 2'd2;
                    req.b0 = VERSION[7:0];
                    req.b1 = VERSION[15:8];
                end
                CMD_TEST_RD: begin
                    req.n  = 2'd1;
                    req.b0 = test_reg;
                end
                default: ;
            endcase
        end else if (done && cmd_q == CMD_INVERT) begin
            req.clear = 1'b1;
            req.n     = 2'd1;
            req.b0    = ~pv[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            need_q     <= 2'd0;
            cmd_q      <= 8'h00;
            pcnt_q     <= '0;
            time_const <= 8'h00;
            rate       <= 16'h0000;
            block_len  <= 17'h0;
            xfer_cmd   <= 8'h00;
            xfer_mode  <= 8'h00;
            xfer_count <= 16'h0000;
            xfer_start <= 1'b0;
            test_reg   <= 8'h00;
            for (int i = 0; i < PBUF_DEPTH; i++) pbuf[i] <= 8'h00;
        end else begin
            xfer_start <= 1'b0;
            if (soft_rst) begin
                need_q <= 2'd0;
                pcnt_q <= '0;
            end else if (is_cmd) begin
                cmd_q  <= wdata;
                need_q <= params_needed(wdata);
                pcnt_q <= '0;
            end else if (is_par && room) begin
                pbuf[pcnt_q] <= wdata;
                pcnt_q       <= pcnt_q + 1'b1;
                if (done) begin
                    need_q <= 2'd0;
                    pcnt_q <= '0;
                    if (is_xfer(cmd_q)) begin
                        xfer_cmd   <= cmd_q;
                        xfer_mode  <= pv[0];
                        xfer_count <= {pv[2], pv[1]};
                        xfer_start <= 1'b1;
                    end else begin
                        case (cmd_q)
                            CMD_TCONST:             time_const <= pv[0];
                            CMD_RATE_A, CMD_RATE_B: rate       <= {pv[0], pv[1]};
                            CMD_BLKLEN:             block_len  <= {1'b0, pv[1], pv[0]} + 17'd1;
                            CMD_TEST_WR:            test_reg   <= pv[0];
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    // R3
    fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_pending) |-> ($past(wr_en) || $past(soft_rst)));

    // R3
    pcnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_pending |-> (pcnt_q < PIW'(need_q)));

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_start |=> !xfer_start);

    // R6
    test_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(test_reg));

endmodule

// File: rtl/dsp_host_port.sv
module dsp_host_port
    import dsp_port_pkg::*;
#(
    parameter logic [15:0] VERSION     = 16'h0405,
    parameter int          PBUF_DEPTH  = 10,
    parameter int          REPLY_DEPTH = 50
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        reply_pending,
    output logic        cmd_pending,
    output logic [7:0]  time_const,
    output logic [15:0] rate,
    output logic [16:0] block_len,
    output logic [7:0]  xfer_cmd,
    output logic [7:0]  xfer_mode,
    output logic [15:0] xfer_count,
    output logic        xfer_start,
    output logic [7:0]  test_reg
);
    logic      wr_rst, wr_cmd, pop, soft_rst;
    push_req_t seq_req, lifo_req;
    logic [7:0] lifo_byte;

    assign wr_rst = bus_wr && (bus_addr == OFF_RESET);
    assign wr_cmd = bus_wr && (bus_addr == OFF_CMD);
    assign pop    = bus_rd && (bus_addr == OFF_RDATA);

    dsp_rst_arm u_arm (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_rst),
        .wdata    (bus_wdata),
        .soft_rst (soft_rst)
    );

    dsp_cmd_seq #(
        .PBUF_DEPTH (PBUF_DEPTH),
        .VERSION    (VERSION)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .soft_rst    (soft_rst),
        .wr_en       (wr_cmd),
        .wdata       (bus_wdata),
        .req         (seq_req),
        .cmd_pending (cmd_pending),
        .time_const  (time_const),
        .rate        (rate),
        .block_len   (block_len),
        .xfer_cmd    (xfer_cmd),
        .xfer_mode   (xfer_mode),
        .xfer_count  (xfer_count),
        .xfer_start  (xfer_start),
        .test_reg    (test_reg)
    );

    always_comb begin
        lifo_req = seq_req;
        if (soft_rst) begin
            lifo_req.clear = 1'b1;
            lifo_req.n     = 2'd1;
            lifo_req.b0    = ACK_BYTE;
            lifo_req.b1    = 8'h00;
        end
    end

    dsp_reply_lifo #(
        .DEPTH (REPLY_DEPTH)
    ) u_lifo (
        .clk     (clk),
        .rst     (rst),
        .req     (lifo_req),
        .pop     (pop),
        .rd_byte (lifo_byte),
        .pending (reply_pending)
    );

    always_comb begin
        case (bus_addr)
            OFF_RDATA:  bus_rdata = lifo_byte;
            OFF_CMD:    bus_rdata = 8'h00;
            OFF_STATUS: bus_rdata = {reply_pending, 7'b0};
            default:    bus_rdata = 8'hFF;
        endcase
    end

    // R2
    soft_rst_effect_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (reply_pending && !cmd_pending));

endmodule

// File: tb/tb_dsp_host_port.sv
`timescale 1ns/1ps
module tb_dsp_host_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = 4'h0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        reply_pending, cmd_pending, xfer_start;
    logic [7:0]  time_const, xfer_cmd, xfer_mode, test_reg;
    logic [15:0] rate, xfer_count;
    logic [16:0] block_len;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    dsp_host_port dut (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_wr        (bus_wr),
        .bus_rd        (bus_rd),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .reply_pending (reply_pending),
        .cmd_pending   (cmd_pending),
        .time_const    (time_const),
        .rate          (rate),
        .block_len     (block_len),
        .xfer_cmd      (xfer_cmd),
        .xfer_mode     (xfer_mode),
        .xfer_count    (xfer_count),
        .xfer_start    (xfer_start),
        .test_reg      (test_reg)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // driver: queue the expected byte, then issue the read
    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    // monitor: compare read data mid-cycle
    always @(negedge clk) begin
        if (bus_rd) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read, actual 0x%0h expected none", bus_rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual 0x%0h expected 0x%0h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic soft_reset(input logic [7:0] arm);
        wr(4'h6, arm);
        wr(4'h6, 8'h00);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;

        // R13 hardware reset state
        chk("R13 reply_pending", reply_pending, 0);
        chk("R13 cmd_pending", cmd_pending, 0);
        chk("R13 time_const", time_const, 0);
        chk("R13 block_len", block_len, 0);
        chk("R13 test_reg", test_reg, 0);
        rd(4'hA, 8'h00, "R10 empty read after hw reset");
        rd(4'hE, 8'h00, "R11 status empty");
        rd(4'hC, 8'h00, "R11 never busy");
        rd(4'h6, 8'hFF, "R11 other offset");

        // R1 unarmed zero does nothing
        wr(4'h6, 8'h00);
        chk("R1 unarmed zero", reply_pending, 0);

        // R1 arm with 0x01 then reset
        soft_reset(8'h01);
        chk("R1 reset via 0x01", reply_pending, 1);
        rd(4'hE, 8'h80, "R11 status pending");
        rd(4'hA, 8'hAA, "R2 ack byte");
        rd(4'hE, 8'h00, "R11 status drained");
        rd(4'hA, 8'hAA, "R10 empty read repeats last");

        // R1 disarm with 0xC6
        wr(4'h6, 8'h03);
        wr(4'h6, 8'hC6);
        wr(4'h6, 8'h00);
        chk("R1 disarmed by 0xC6", reply_pending, 0);

        // R1 arm with 0x03
        soft_reset(8'h03);
        chk("R1 reset via 0x03", reply_pending, 1);
        rd(4'hA, 8'hAA, "R1 ack after 0x03");

        // R5 time constant
        wr(4'hC, 8'h40);
        chk("R3 pending after 0x40", cmd_pending, 1);
        wr(4'hC, 8'hA5);
        chk("R5 time_const", time_const, 8'hA5);
        chk("R3 completes", cmd_pending, 0);

        // R5 rate, high byte first
        wr(4'hC, 8'h41); wr(4'hC, 8'h56); wr(4'hC, 8'h22);
        chk("R5 rate 0x41", rate, 16'h5622);
        wr(4'hC, 8'h42); wr(4'hC, 8'hAC); wr(4'hC, 8'h44);
        chk("R5 rate 0x42", rate, 16'hAC44);

        // R5 block length, low byte first, plus one
        wr(4'hC, 8'h48); wr(4'hC, 8'hFF); wr(4'hC, 8'h0F);
        chk("R5 block_len", block_len, 17'h01000);
        wr(4'hC, 8'h48); wr(4'hC, 8'hFF); wr(4'hC, 8'hFF);
        chk("R5 block_len max", block_len, 17'h10000);

        // R4 transfer commands
        wr(4'hC, 8'hB6); wr(4'hC, 8'h10); wr(4'hC, 8'h34);
        chk("R4 still pending after 2 bytes", cmd_pending, 1);
        wr(4'hC, 8'h12);
        chk("R4 xfer_start pulse", xfer_start, 1);
        chk("R4 xfer_cmd", xfer_cmd, 8'hB6);
        chk("R4 xfer_mode", xfer_mode, 8'h10);
        chk("R4 xfer_count", xfer_count, 16'h1234);
        @(posedge clk); #1;
        chk("R4 xfer_start one cycle", xfer_start, 0);
        wr(4'hC, 8'hCF); wr(4'hC, 8'h20); wr(4'hC, 8'h01); wr(4'hC, 8'h00);
        chk("R4 top of range cmd", xfer_cmd, 8'hCF);
        chk("R4 top of range count", xfer_count, 16'h0001);
        chk("R4 top of range mode", xfer_mode, 8'h20);

        // R6 test register
        wr(4'hC, 8'hE4); wr(4'hC, 8'h5A);
        chk("R6 test_reg", test_reg, 8'h5A);
        wr(4'hC, 8'hE8);
        rd(4'hA, 8'h5A, "R6 0xE8 reply");

        // R9 unrecognised commands take no parameters
        wr(4'hC, 8'h35);
        chk("R9 no pending after 0x35", cmd_pending, 0);
        chk("R9 no reply after 0x35", reply_pending, 0);
        wr(4'hC, 8'hAF);
        chk("R9 no pending after 0xAF", cmd_pending, 0);
        wr(4'hC, 8'hE8);
        rd(4'hA, 8'h5A, "R9 next byte decoded as command");

        // R7 invert clears pending replies
        wr(4'hC, 8'hE8); wr(4'hC, 8'hE8);
        wr(4'hC, 8'hE0); wr(4'hC, 8'h3C);
        rd(4'hA, 8'hC3, "R7 inverted byte");
        rd(4'hE, 8'h00, "R7 older replies cleared");

        // R8 version, major byte first
        wr(4'hC, 8'hE1);
        rd(4'hA, 8'h04, "R8 version major");
        rd(4'hA, 8'h05, "R8 version minor");

        // R12 fill the reply stack to its depth
        for (int i = 0; i < 24; i++) wr(4'hC, 8'hE1);
        wr(4'hC, 8'hE8);
        wr(4'hC, 8'hE4); wr(4'hC, 8'h77);
        wr(4'hC, 8'hE8);
        wr(4'hC, 8'hE1);
        wr(4'hC, 8'hE8);
        rd(4'hA, 8'h77, "R12 top after overflow pushes dropped");
        rd(4'hA, 8'h5A, "R12 second entry");
        for (int i = 0; i < 24; i++) begin
            rd(4'hA, 8'h04, "R12 stacked version major");
            rd(4'hA, 8'h05, "R12 stacked version minor");
        end
        rd(4'hE, 8'h00, "R12 exactly depth entries held");

        // R2 soft reset mid-command keeps decoded outputs
        wr(4'hC, 8'h40);
        chk("R2 pending before reset", cmd_pending, 1);
        soft_reset(8'h01);
        chk("R2 pending cleared", cmd_pending, 0);
        chk("R2 time_const kept", time_const, 8'hA5);
        wr(4'hC, 8'hE8);
        chk("R2 byte after reset is a command", time_const, 8'hA5);
        rd(4'hA, 8'h77, "R2 reply pushed on top of ack");
        rd(4'hA, 8'hAA, "R2 ack is only prior reply");
        rd(4'hE, 8'h00, "R2 stack then empty");

        repeat (4) @(posedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule